// File: doc/BRIEF.md
# Predicated Single-to-Bfloat16 Vector Narrowing Converter

This block takes a vector of 32-bit single-precision lanes and narrows each selected lane to a bfloat16 value. A per-byte predicate vector selects the lanes. The block serves as the datapath of a vector conversion operation. It takes the source vector, the predicate and the current contents of the destination. It returns the new destination vector. It also returns a small set of IEEE exception flags, gathered from the lanes that were converted.

Each 16-bit result sits in the low half of its own 32-bit lane, and the high half is cleared. A mode input chooses what happens to lanes that are not selected: they keep the old destination value, or they are cleared. The rounding direction comes from an input. Two more inputs control NaN canonicalisation and flushing of subnormals. The result can be registered once, under a parameter, with a valid bit that follows the data.

Top module: `bf16_vec_cvt`

## Requirements
- R1: A lane l is active when predicate bit 4*l is set. The other three predicate bits of the lane have no effect. For an active lane, output bits [32l+15:32l] hold the bfloat16 result, and bits [32l+31:32l+16] are zero.
- R2: When zero_mode_i is 0 (merge), an inactive lane outputs the full 32-bit value of dst_old_i for that lane.
- R3: When zero_mode_i is 1 (zeroing), an inactive lane outputs all zeros.
- R4: With rnd_mode_i = 0, rounding is to nearest, with ties to even, on the 16 discarded mantissa bits.
- R5: rnd_mode_i = 1 rounds toward +infinity, 2 rounds toward -infinity and 3 rounds toward zero.
- R6: A signalling NaN input (exponent all ones, mantissa nonzero, mantissa bit 22 clear) gives a quiet NaN. That NaN keeps the sign and the top payload bits, and has bfloat16 bit 6 set. It also sets flag bit 0 (invalid). A quiet NaN or an infinity passes through with no flag.
- R7: When dflt_nan_i is 1, every NaN result is 0x7FC0.
- R8: When flush_i is 1, a subnormal input becomes a signed zero and sets flag bit 1 (input denormal). When flush_i is 0, a subnormal input is rounded like any other value.
- R9: If rounding carries the exponent to all ones, the result is a signed infinity, and flag bit 2 (overflow) and flag bit 3 (inexact) are set. A rounding mode that truncates toward the largest finite value gives 0x7F7F or 0xFF7F with inexact only.
- R10: Flag bit 3 (inexact) is set when any discarded mantissa bit of a finite active lane is nonzero.
- R11: flags_o is the OR of the flags of active lanes only. Inactive lanes never set a flag.
- R12: With no active lane, the output equals dst_old_i in merge mode and is all zeros in zeroing mode, and the flags are zero.
- R13: With OUT_REG = 1, dst_o, flags_o and valid_o appear one clock after valid_i is set. valid_o drops one clock after valid_i drops, and dst_o holds its last value. After reset, valid_o, dst_o and flags_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Inputs hold an operation |
| src_i | input | VLEN | Source single-precision lanes |
| pred_i | input | VLEN/8 | Predicate, one bit per byte |
| dst_old_i | input | VLEN | Previous destination contents |
| zero_mode_i | input | 1 | 1: clear inactive lanes, 0: keep them |
| rnd_mode_i | input | 2 | 0 nearest-even, 1 up, 2 down, 3 toward zero |
| dflt_nan_i | input | 1 | Replace NaN results with the canonical NaN |
| flush_i | input | 1 | Flush subnormal inputs to zero |
| valid_o | output | 1 | dst_o and flags_o hold a result |
| dst_o | output | VLEN | Converted destination vector |
| flags_o | output | 4 | {inexact, overflow, input denormal, invalid} |

## Verification
The bench drives whole vectors, and every lane carries a different corner value. This way a mistake in one lane's position, or in the lane select, shows up as a wrong lane and cannot pass unseen.

The rounding vectors hold exact values, exact ties on both even and odd kept mantissas, and just-above-tie values. Each is run under all four rounding directions, so the tie-breaking rule and the sign dependence of directed rounding can be told apart.

The special-value vectors contain signalling and quiet NaNs, infinities, subnormals and near-maximum values. They are run with the default-NaN and flush controls both on and off.

The predicate patterns are all lanes, single lanes, and groups where only the non-leading bits are set. They are run in both fill modes. Some patterns put a signalling NaN in an inactive lane, so that flag leakage from unselected lanes is caught.

// File: rtl/bf16_cvt_pkg.sv
package bf16_cvt_pkg;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_UP   = 2'd1,
    RM_DOWN = 2'd2,
    RM_ZERO = 2'd3
  } rnd_mode_t;

  typedef struct packed {
    logic inexact;
    logic overflow;
    logic in_denorm;
    logic invalid;
  } cvt_flags_t;

  localparam logic [15:0] BF_DFLT_NAN = 16'h7FC0;

endpackage

// File: rtl/bf16_lane_cvt.sv
module bf16_lane_cvt
  import bf16_cvt_pkg::*;
(
  input  logic [31:0] fp_i,
  input  rnd_mode_t   rm_i,
  input  logic        dflt_nan_i,
  input  logic        flush_i,
  output logic [15:0] bf_o,
  output cvt_flags_t  flags_o
);

  logic        sgn;
  logic [7:0]  expo;
  logic [22:0] man;
  logic [14:0] keep;
  logic [15:0] rem;
  logic        is_nan, is_inf, is_sub;
  logic        inc;
  logic [14:0] sum;
  logic        ovf;

  always_comb begin
    sgn    = fp_i[31];
    expo   = fp_i[30:23];
    man    = fp_i[22:0];
    keep   = fp_i[30:16];
    rem    = fp_i[15:0];
    is_nan = (&expo) && (|man);
    is_inf = (&expo) && !(|man);
    is_sub = !(|expo) && (|man);

    unique case (rm_i)
      RM_NEAR: inc = rem[15] && ((|rem[14:0]) || keep[0]);
      RM_UP:   inc = !sgn && (|rem);
      RM_DOWN: inc = sgn && (|rem);
      default: inc = 1'b0;
    endcase

    sum = keep + 15'(inc);
    // carry into an all-ones exponent can only come from rounding
    ovf = inc && (&sum[14:7]);

    flags_o = '0;
    bf_o    = {sgn, sum};
    if (is_nan) begin
      bf_o            = dflt_nan_i ? BF_DFLT_NAN : {sgn, 8'hFF, 1'b1, man[21:16]};
      flags_o.invalid = !man[22];
    end else if (is_inf) begin
      bf_o = {sgn, 15'h7F80};
    end else if (is_sub && flush_i) begin
      bf_o              = {sgn, 15'h0000};
      flags_o.in_denorm = 1'b1;
    end else begin
      flags_o.inexact  = |rem;
      flags_o.overflow = ovf;
    end
  end

endmodule

// File: rtl/bf16_out_stage.sv
module bf16_out_stage #(
  parameter int W   = 32,
  parameter bit REG = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] d_i,
  output logic         valid_o,
  output logic [W-1:0] q_o
);

  if (REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o <= 1'b0;
        q_o     <= '0;
      end else begin
        valid_o <= valid_i;
        if (valid_i) q_o <= d_i;
      end
    end

    // R13
    valid_pipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> (valid_o && q_o == $past(d_i)));
    // R13
    valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> (!valid_o && $stable(q_o)));
  end else begin : g_comb
    assign valid_o = valid_i;
    assign q_o     = d_i;

    // R13
    valid_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o == valid_i);
  end

endmodule

// File: rtl/bf16_vec_cvt.sv
module bf16_vec_cvt
  import bf16_cvt_pkg::*;
#(
  parameter int VLEN    = 128,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [VLEN-1:0]   src_i,
  input  logic [VLEN/8-1:0] pred_i,
  input  logic [VLEN-1:0]   dst_old_i,
  input  logic              zero_mode_i,
  input  logic [1:0]        rnd_mode_i,
  input  logic              dflt_nan_i,
  input  logic              flush_i,
  output logic              valid_o,
  output logic [VLEN-1:0]   dst_o,
  output logic [3:0]        flags_o
);

  localparam int LANES = VLEN / 32;
  localparam int FW    = $bits(cvt_flags_t);

  logic [LANES-1:0] act;
  logic             any_act;
  logic [VLEN-1:0]  opnd;
  logic [VLEN-1:0]  res_c;
  logic [FW-1:0]    flags_c;
  cvt_flags_t       lane_flg [LANES];
  logic [15:0]      lane_bf  [LANES];
  logic             unused_pred;

  assign unused_pred = ^pred_i;
  assign any_act     = |act;
  // source is gated off when nothing is selected
  assign opnd        = any_act ? src_i : '0;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign act[l] = pred_i[4*l];

    bf16_lane_cvt u_cvt (
      .fp_i      (opnd[32*l +: 32]),
      .rm_i      (rnd_mode_t'(rnd_mode_i)),
      .dflt_nan_i(dflt_nan_i),
      .flush_i   (flush_i),
      .bf_o      (lane_bf[l]),
      .flags_o   (lane_flg[l])
    );

    always_comb begin
      if (act[l])          res_c[32*l +: 32] = {16'h0000, lane_bf[l]};
      else if (zero_mode_i) res_c[32*l +: 32] = '0;
      else                 res_c[32*l +: 32] = dst_old_i[32*l +: 32];
    end

    // R1
    lane_hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && pred_i[4*l]) |-> (res_c[32*l+16 +: 16] == 16'h0000));
    // R2
    merge_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !pred_i[4*l] && !zero_mode_i) |-> (res_c[32*l +: 32] == dst_old_i[32*l +: 32]));
    // R3
    zero_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !pred_i[4*l] && zero_mode_i) |-> (res_c[32*l +: 32] == 32'h0));
    // R6
    snan_invalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && pred_i[4*l] && (&src_i[32*l+23 +: 8]) && (|src_i[32*l +: 22]) && !src_i[32*l+22])
        |-> flags_c[0]);
  end

  always_comb begin
    flags_c = '0;
    for (int l = 0; l < LANES; l++) begin
      if (act[l]) flags_c = flags_c | lane_flg[l];
    end
  end

  // R11
  no_act_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !(|act)) |-> (flags_c == '0));
  // R9
  ovf_inexact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && flags_c[2]) |-> flags_c[3]);

  bf16_out_stage #(
    .W  (VLEN + FW),
    .REG(OUT_REG)
  ) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .d_i    ({flags_c, res_c}),
    .valid_o(valid_o),
    .q_o    ({flags_o, dst_o})
  );

endmodule

// File: tb/bf16_vec_cvt_bench.sv
`timescale 1ns/1ps
module bf16_vec_cvt_bench;

  localparam int VLEN  = 128;
  localparam int LANES = VLEN / 32;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              valid_i = 1'b0;
  logic [VLEN-1:0]   src_i = '0;
  logic [VLEN/8-1:0] pred_i = '0;
  logic [VLEN-1:0]   dst_old_i = '0;
  logic              zero_mode_i = 1'b0;
  logic [1:0]        rnd_mode_i = 2'd0;
  logic              dflt_nan_i = 1'b0;
  logic              flush_i = 1'b0;
  logic              valid_o;
  logic [VLEN-1:0]   dst_o;
  logic [3:0]        flags_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  bf16_vec_cvt #(.VLEN(VLEN), .OUT_REG(1'b1)) u_bf16_vec_cvt (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .src_i(src_i), .pred_i(pred_i),
    .dst_old_i(dst_old_i), .zero_mode_i(zero_mode_i), .rnd_mode_i(rnd_mode_i),
    .dflt_nan_i(dflt_nan_i), .flush_i(flush_i), .valid_o(valid_o), .dst_o(dst_o),
    .flags_o(flags_o)
  );

  // reference: returns {flags[3:0], bf[15:0]}, flags = {inexact, overflow, denorm, invalid}
  function automatic logic [19:0] ref_cvt(input logic [31:0] x, input int rm, input bit dn, input bit ftz);
    int unsigned mag, low, hi;
    bit neg, up;
    logic [3:0] f;
    logic [15:0] r;
    neg = x[31];
    mag = x & 32'h7FFF_FFFF;
    f   = 4'h0;
    if (mag > 32'h7F80_0000) begin
      if ((mag & 32'h0040_0000) == 0) f[0] = 1'b1;
      r = dn ? 16'h7FC0 : (16'(x >> 16) | 16'h0040);
    end else if (mag == 32'h7F80_0000) begin
      r = 16'(x >> 16);
    end else if (mag < 32'h0080_0000 && mag != 0 && ftz) begin
      r    = neg ? 16'h8000 : 16'h0000;
      f[1] = 1'b1;
    end else begin
      hi  = mag / 65536;
      low = mag % 65536;
      case (rm)
        0:       up = (low > 32768) || (low == 32768 && (hi % 2 == 1));
        1:       up = !neg && low != 0;
        2:       up = neg && low != 0;
        default: up = 1'b0;
      endcase
      if (up) hi = hi + 1;
      if (low != 0) f[3] = 1'b1;
      if (hi >= 32'h7F80) f[2] = 1'b1;
      r = {neg, 15'(hi)};
    end
    return {f, r};
  endfunction

  task automatic check(input string tag, input logic [VLEN-1:0] act_v, input logic [VLEN-1:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act_v, exp_v);
    end
  endtask

  task automatic run_vec(input string tag, input logic [VLEN-1:0] src, input logic [VLEN/8-1:0] pred,
                         input logic [VLEN-1:0] old, input bit zm, input int rm, input bit dn, input bit ftz);
    logic [VLEN-1:0] exp_d;
    logic [3:0] exp_f;
    logic [19:0] rv;
    @(negedge clk);
    src_i = src; pred_i = pred; dst_old_i = old; zero_mode_i = zm;
    rnd_mode_i = 2'(rm); dflt_nan_i = dn; flush_i = ftz; valid_i = 1'b1;
    exp_f = 4'h0;
    for (int l = 0; l < LANES; l++) begin
      if (pred[4*l]) begin
        rv = ref_cvt(src[32*l +: 32], rm, dn, ftz);
        exp_d[32*l +: 32] = {16'h0000, rv[15:0]};
        exp_f = exp_f | rv[19:16];
      end else begin
        exp_d[32*l +: 32] = zm ? 32'h0 : old[32*l +: 32];
      end
    end
    @(posedge clk);
    #1;
    check({tag, " valid"}, VLEN'(valid_o), VLEN'(1'b1));
    check({tag, " data"}, dst_o, exp_d);
    check({tag, " flags"}, VLEN'(flags_o), VLEN'(exp_f));
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  localparam logic [VLEN-1:0] OLD = 128'hDEAD_BEEF_CAFE_F00D_1234_5678_9ABC_DEF0;

  initial begin
    logic [VLEN-1:0] held;
    #10;
    // R13 reset state
    check("R13 reset valid", VLEN'(valid_o), '0);
    check("R13 reset data", dst_o, '0);
    check("R13 reset flags", VLEN'(flags_o), '0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R1 R4 R10 nearest-even: exact, tie even, tie odd, above tie
    run_vec("R4", {32'h3F80_8001, 32'h3F81_8000, 32'h3F80_8000, 32'h3F80_0000}, 16'h1111, OLD, 0, 0, 0, 0);
    run_vec("R10", {32'h3F80_7FFF, 32'hBF80_0001, 32'h4049_0FDB, 32'h0000_0000}, 16'h1111, OLD, 0, 0, 0, 0);
    // R5 directed modes
    for (int m = 1; m < 4; m++)
      run_vec("R5", {32'h3F80_8000, 32'h4049_0FDB, 32'hBF80_0001, 32'h3F80_0001}, 16'h1111, OLD, 0, m, 0, 0);
    // R6 R7 NaN handling
    run_vec("R6", {32'hFF80_0000, 32'h7FC0_1234, 32'hFFA1_2345, 32'h7F80_0001}, 16'h1111, OLD, 0, 0, 0, 0);
    run_vec("R7", {32'hFF80_0000, 32'h7FC0_1234, 32'hFFA1_2345, 32'h7F80_0001}, 16'h1111, OLD, 0, 0, 1, 0);
    // R8 subnormals with and without flush
    run_vec("R8", {32'h0000_0000, 32'h3F80_0000, 32'h8000_0001, 32'h0040_0000}, 16'h1111, OLD, 0, 0, 0, 1);
    run_vec("R8", {32'h0000_0000, 32'h007F_FFFF, 32'h8000_0001, 32'h0040_0000}, 16'h1111, OLD, 0, 0, 0, 0);
    // R9 overflow under rounding modes
    run_vec("R9", {32'h3F80_0000, 32'h7F7F_8000, 32'hFF7F_FFFF, 32'h7F7F_FFFF}, 16'h1111, OLD, 0, 0, 0, 0);
    run_vec("R9", {32'h3F80_0000, 32'h7F7F_8000, 32'hFF7F_FFFF, 32'h7F7F_FFFF}, 16'h1111, OLD, 0, 3, 0, 0);
    run_vec("R9", {32'h3F80_0000, 32'h7F7F_8000, 32'hFF7F_FFFF, 32'h7F7F_FFFF}, 16'h1111, OLD, 0, 2, 0, 0);
    // R1 R2 merge with single lane, non-leading bits set
    run_vec("R2", {32'h4000_0000, 32'h4040_0000, 32'h4080_0000, 32'h3F80_0000}, 16'hEE0F, OLD, 0, 0, 0, 0);
    // R3 zeroing, lanes 1 and 3
    run_vec("R3", {32'h4000_0000, 32'h4040_0000, 32'h4080_0000, 32'h3F80_0000}, 16'h1010, OLD, 1, 0, 0, 0);
    // R11 signalling NaN and overflow candidate in inactive lanes
    run_vec("R11", {32'h7F80_0001, 32'h3F80_0000, 32'h7F7F_FFFF, 32'h3F80_0000}, 16'h0101, OLD, 0, 0, 0, 0);
    // R12 no active lane, only non-leading bits set
    run_vec("R12", {32'h7F80_0001, 32'h3F80_8001, 32'h7F7F_FFFF, 32'h0040_0000}, 16'hEEEE, OLD, 0, 0, 0, 1);
    run_vec("R12", {32'h7F80_0001, 32'h3F80_8001, 32'h7F7F_FFFF, 32'h0040_0000}, 16'h0000, OLD, 1, 0, 0, 1);

    // R13 valid drops and data holds
    held = dst_o;
    @(posedge clk);
    #1;
    check("R13 valid drop", VLEN'(valid_o), '0);
    check("R13 data hold", dst_o, held);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule